// File: doc/BRIEF.md
# LIN bit timing generator with header resynchronisation

This block turns the system clock into the sampling and bit timing used by a serial receiver in UART or LIN slave use. A free-running prescaler divides the clock by `divider + 1` to make a sample strobe. A second counter divides the sample strobe by a samples-per-bit count. The bit rate is therefore the clock rate divided by `spb × (divider + 1)`. Each received bit is decided by a majority vote over three samples taken around the middle of the bit.

In UART mode (`lin_mode = 0`) the samples-per-bit count comes from `spb_cfg`. Every falling edge seen while idle starts a 10-bit frame: a start bit, eight data bits sent LSB first, and a stop bit.

In LIN slave mode (`lin_mode = 1`) the block hunts for a header with the count held at 32. When it sees a dominant period, it measures how long the period lasts and accepts it as a break only inside a length window. It then times the 0x55 sync field over eight bit times and sets a new samples-per-bit count from that timing, as long as the result lies inside the allowed deviation. The identifier byte that follows is received with this new count. Once that byte is done, the block returns to hunting at the nominal count.

Top module: `lin_bitclk_resync`

## Requirements
- R1: `sample_tick` is high for one clock in every `divider + 1` clocks, for any divider value from 0 to 4095.
- R2: After reset in LIN mode, `spb_now` is 32. In UART mode, `spb_now` equals `spb_cfg`. Supported values are 6 to 63.
- R3: A falling edge of `rx` while idle starts a frame of 10 bits, each lasting `spb_now` samples. `bit_tick` pulses once at the end of each bit, and `bit_val` carries the decision: start (0), data bits LSB first, stop (1). The block then returns to idle.
- R4: Each bit is decided by a majority of the samples at positions spb/2−1, spb/2 and spb/2+1, counted from the bit's first sample. A single disturbed sample inside that window does not change the result.
- R5: In LIN mode, while hunting for a break, measuring a break or timing the sync field, `spb_now` is 32.
- R6: A dominant period lasting N samples is accepted as a break, with a one-cycle `brk_ok` pulse, only if 352 ≤ N ≤ 896 (11 to 28 bit times of 32 samples). Otherwise no pulse is given and hunting continues.
- R7: After an accepted break, the time M (in samples) from the sync start-bit falling edge to the fifth falling edge (bit 7) is measured. The new count is (M + 4) / 8, rounded down. A one-cycle `sync_done` pulse is given, and `spb_now` shows the new count.
- R8: If the new count falls outside 26..38, or M passes 320 samples before the fifth edge, a one-cycle `sync_err` pulse is given. The block then goes back to hunting with `spb_now` left at 32.
- R9: After `sync_done`, the next falling edge starts the identifier frame, which is received with the new count. When that frame ends, `spb_now` returns to 32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| divider | input | 12 | Prescaler divide value minus one |
| spb_cfg | input | 6 | Samples per bit in UART mode |
| lin_mode | input | 1 | 1 = LIN slave header handling, 0 = plain UART |
| rx | input | 1 | Serial line, idle high |
| sample_tick | output | 1 | Sample strobe from the prescaler |
| bit_tick | output | 1 | One-cycle strobe at the end of each received bit |
| bit_val | output | 1 | Voted value of the last bit |
| brk_ok | output | 1 | Pulse when a break is accepted |
| sync_done | output | 1 | Pulse when the sync field tuned the bit timing |
| sync_err | output | 1 | Pulse when the sync timing is out of range |
| spb_now | output | 6 | Samples-per-bit count currently in use |

## Verification
The bench uses a divider of 0 so that break lengths can be set to the exact sample. It drives breaks of 351, 352, 896 and 897 samples, so an off-by-one length window shows up as a missing or extra `brk_ok`. It sends sync fields at 28, 36 and 38 clocks per bit. A wrong rounding or a missing retune shows up in `spb_now` or as corrupted identifier bits, because the drift builds up over the frame. Sync fields at 20 and 45 clocks per bit must end in `sync_err`. A one-clock glitch placed at the exact centre sample of every bit catches a receiver that takes a single sample instead of voting. Random dividers and UART frames check the prescaler period and the bit ordering.

// File: rtl/lin_bitclk_resync.sv
module lin_bitclk_resync #(
  parameter int DIVW    = 12,
  parameter int SPBW    = 6,
  parameter int SPB_NOM = 32,
  parameter int BRK_MIN = 11,
  parameter int BRK_MAX = 28,
  parameter int SPB_LO  = 26,
  parameter int SPB_HI  = 38,
  parameter int MEASW   = 10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [DIVW-1:0] divider,
  input  logic [SPBW-1:0] spb_cfg,
  input  logic            lin_mode,
  input  logic            rx,
  output logic            sample_tick,
  output logic            bit_tick,
  output logic            bit_val,
  output logic            brk_ok,
  output logic            sync_done,
  output logic            sync_err,
  output logic [SPBW-1:0] spb_now
);
  localparam logic [SPBW-1:0]  NOM    = SPBW'(SPB_NOM);
  localparam logic [SPBW-1:0]  TLO    = SPBW'(SPB_LO);
  localparam logic [SPBW-1:0]  THI    = SPBW'(SPB_HI);
  localparam logic [MEASW-1:0] BRK_LO = MEASW'(BRK_MIN * SPB_NOM);
  localparam logic [MEASW-1:0] BRK_HI = MEASW'(BRK_MAX * SPB_NOM);
  localparam logic [MEASW:0]   M_MAX  = (MEASW + 1)'(8 * SPB_HI + 16);
  localparam logic [3:0]       LAST   = 4'd9;

  typedef enum logic [2:0] {S_IDLE, S_BRK, S_SYNW, S_SYNM, S_WPID, S_FRM} st_t;
  st_t st;

  logic [DIVW-1:0]  pcnt;
  logic             rx_m, rx_s, rx_p;
  logic [SPBW-1:0]  scnt, tuned;
  logic             tuned_ok;
  logic [3:0]       bidx;
  logic [2:0]       votes;
  logic [MEASW-1:0] meas;
  logic [1:0]       ecnt;

  assign sample_tick = pcnt >= divider;
  assign spb_now = lin_mode ? (tuned_ok ? tuned : NOM) : spb_cfg;

  wire             fall   = sample_tick & rx_p & ~rx_s;
  wire [SPBW-1:0]  half   = spb_now >> 1;
  wire             maj    = (votes[0] & votes[1]) | (votes[0] & votes[2]) | (votes[1] & votes[2]);
  wire [MEASW:0]   meas_n = {1'b0, meas} + 1'b1;
  wire [MEASW:0]   rsum   = meas_n + (MEASW + 1)'(4);
  wire [SPBW-1:0]  rnd    = SPBW'(rsum >> 3);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcnt <= '0;
      rx_m <= 1'b1;
      rx_s <= 1'b1;
      rx_p <= 1'b1;
    end else begin
      pcnt <= sample_tick ? '0 : pcnt + 1'b1;
      rx_m <= rx;
      rx_s <= rx_m;
      if (sample_tick) rx_p <= rx_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      scnt <= '0;
      tuned <= NOM;
      tuned_ok <= 1'b0;
      bidx <= '0;
      votes <= '0;
      meas <= '0;
      ecnt <= '0;
      bit_tick <= 1'b0;
      bit_val <= 1'b1;
      brk_ok <= 1'b0;
      sync_done <= 1'b0;
      sync_err <= 1'b0;
    end else begin
      bit_tick <= 1'b0;
      brk_ok <= 1'b0;
      sync_done <= 1'b0;
      sync_err <= 1'b0;
      if (sample_tick) begin
        case (st)
          S_IDLE: if (fall) begin
            if (lin_mode) begin
              st <= S_BRK;
              meas <= MEASW'(1);
            end else begin
              st <= S_FRM;
              scnt <= '0;
              bidx <= '0;
            end
          end
          S_BRK: begin
            if (rx_s) begin
              if (meas >= BRK_LO && meas <= BRK_HI) begin
                brk_ok <= 1'b1;
                st <= S_SYNW;
              end else begin
                st <= S_IDLE;
              end
            end else if (meas != '1) begin
              meas <= meas + 1'b1;
            end
          end
          S_SYNW: if (fall) begin
            st <= S_SYNM;
            meas <= '0;
            ecnt <= '0;
          end
          S_SYNM: begin
            meas <= meas_n[MEASW-1:0];
            if (fall) begin
              if (ecnt == 2'd3) begin
                if (rnd >= TLO && rnd <= THI) begin
                  tuned <= rnd;
                  tuned_ok <= 1'b1;
                  sync_done <= 1'b1;
                  st <= S_WPID;
                end else begin
                  sync_err <= 1'b1;
                  st <= S_IDLE;
                end
              end else begin
                ecnt <= ecnt + 1'b1;
              end
            end else if (meas_n > M_MAX) begin
              sync_err <= 1'b1;
              st <= S_IDLE;
            end
          end
          S_WPID: if (fall) begin
            st <= S_FRM;
            scnt <= '0;
            bidx <= '0;
          end
          S_FRM: begin
            if (scnt == half - 1'b1) votes[0] <= rx_s;
            if (scnt == half)        votes[1] <= rx_s;
            if (scnt == half + 1'b1) votes[2] <= rx_s;
            if (scnt == spb_now - 1'b1) begin
              scnt <= '0;
              bit_tick <= 1'b1;
              bit_val <= maj;
              bidx <= bidx + 1'b1;
              if (bidx == LAST) begin
                st <= S_IDLE;
                tuned_ok <= 1'b0;
              end
            end else begin
              scnt <= scnt + 1'b1;
            end
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  // R1: a strobe is never followed at once by another while the divide value is stable and nonzero
  p_tick_gap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_tick && divider != '0) |=> (!sample_tick || !$stable(divider)));

  // R3: bit decisions only come out of a sample-strobe cycle
  p_bit_on_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
    bit_tick |-> $past(sample_tick));

  // R5: nominal count while hunting, measuring a break or timing the sync field
  p_hunt_nominal_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (lin_mode && (st == S_IDLE || st == S_BRK || st == S_SYNW || st == S_SYNM)) |-> spb_now == NOM);

  // R6: the header event pulses never coincide
  p_pulse_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({brk_ok, sync_done, sync_err}));

  // R7: a tuned count is always inside the accepted window
  p_tuned_window_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (lin_mode && sync_done) |-> (spb_now >= TLO && spb_now <= THI));

  // R8: an error pulse leaves the block hunting at the nominal count
  p_err_hunt_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (lin_mode && sync_err) |-> spb_now == NOM);
endmodule

// File: tb/lin_bitclk_resync_tb.sv
module lin_bitclk_resync_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [11:0] divider = '0;
  logic [5:0] spb_cfg = 6'd32;
  logic lin_mode = 1'b1;
  logic rx = 1'b1;
  logic sample_tick, bit_tick, bit_val, brk_ok, sync_done, sync_err;
  logic [5:0] spb_now;

  lin_bitclk_resync u_dut (
    .clk(clk), .rst_n(rst_n), .divider(divider), .spb_cfg(spb_cfg),
    .lin_mode(lin_mode), .rx(rx), .sample_tick(sample_tick), .bit_tick(bit_tick),
    .bit_val(bit_val), .brk_ok(brk_ok), .sync_done(sync_done), .sync_err(sync_err),
    .spb_now(spb_now)
  );

  always #5 clk = ~clk;

  int total = 0, bad = 0, cyc = 0;
  int nb = 0, n_brk = 0, n_done = 0, n_err = 0;
  logic got [0:15];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (bit_tick) begin
      if (nb < 16) got[nb] = bit_val;
      nb++;
    end
    if (brk_ok) n_brk++;
    if (sync_done) n_done++;
    if (sync_err) n_err++;
    if (cyc > 150000) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  function automatic int exp_gap(input int d);
    return d + 1;
  endfunction

  function automatic bit exp_brk(input int n);
    return (n >= 11 * 32) && (n <= 28 * 32);
  endfunction

  function automatic int exp_spb(input int bitclk);
    int r = (8 * bitclk + 4) / 8;
    if (8 * bitclk > 320 || r < 26 || r > 38) return 32;
    return r;
  endfunction

  task automatic do_reset(input logic mode);
    lin_mode = mode;
    rx = 1'b1;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    nb = 0; n_brk = 0; n_done = 0; n_err = 0;
  endtask

  task automatic idle(input int n);
    rx = 1'b1;
    repeat (n) @(negedge clk);
  endtask

  task automatic send_frame(input logic [7:0] b, input int l, input bit glitch);
    for (int i = 0; i < 10; i++) begin
      logic v;
      v = (i == 0) ? 1'b0 : (i == 9) ? 1'b1 : b[i-1];
      rx = v;
      if (glitch) begin
        repeat (16) @(negedge clk);
        rx = ~v;
        @(negedge clk);
        rx = v;
        repeat (l - 17) @(negedge clk);
      end else begin
        repeat (l) @(negedge clk);
      end
    end
    rx = 1'b1;
  endtask

  task automatic check_frame(input logic [7:0] b, input string tag);
    logic [7:0] d;
    chk(nb == 10, {tag, " bit count"}, nb, 10);
    for (int i = 0; i < 8; i++) d[i] = got[i+1];
    chk(got[0] == 1'b0 && got[9] == 1'b1, {tag, " start/stop"}, {got[0], got[9]}, 1);
    chk(d == b, {tag, " data"}, d, b);
  endtask

  task automatic send_break(input int n);
    rx = 1'b0;
    repeat (n) @(negedge clk);
    idle(40);
  endtask

  task automatic header(input int brk, input int l);
    send_break(brk);
    send_frame(8'h55, l, 1'b0);
  endtask

  initial begin
    int seed;
    seed = $urandom(32'd20250611);

    do_reset(1'b1);
    chk(spb_now == 6'd32, "R2 reset count", spb_now, 32);
    chk(bit_tick == 1'b0 && brk_ok == 1'b0, "R2 reset pulses", {bit_tick, brk_ok}, 0);

    // R1: prescaler period, random and extreme dividers
    for (int k = 0; k < 7; k++) begin
      int d, gap;
      d = (k == 6) ? 4095 : (k == 5) ? 0 : int'($urandom_range(20, 1));
      divider = 12'(d);
      for (int w = 0; w < 2; w++) begin
        do @(negedge clk); while (!sample_tick);
      end
      gap = 0;
      do begin @(negedge clk); gap++; end while (!sample_tick);
      chk(gap == exp_gap(d), "R1 strobe period", gap, exp_gap(d));
    end

    // R3 R2: random UART frames
    for (int k = 0; k < 8; k++) begin
      int d, s, l;
      logic [7:0] b;
      d = int'($urandom_range(3, 0));
      s = int'($urandom_range(40, 8));
      b = 8'($urandom);
      divider = 12'(d);
      spb_cfg = 6'(s);
      do_reset(1'b0);
      chk(spb_now == 6'(s), "R2 uart count", spb_now, s);
      l = s * (d + 1);
      idle(2 * l);
      nb = 0;
      send_frame(b, l, 1'b0);
      idle(2 * l);
      check_frame(b, "R3 uart frame");
    end

    // R4: one-sample glitch at each bit centre
    divider = '0;
    spb_cfg = 6'd32;
    do_reset(1'b0);
    idle(64);
    nb = 0;
    send_frame(8'hA5, 32, 1'b1);
    idle(64);
    check_frame(8'hA5, "R4 vote glitch");
    nb = 0;
    send_frame(8'h3C, 32, 1'b1);
    idle(64);
    check_frame(8'h3C, "R4 vote glitch 2");

    // R6 R5: break length window
    do_reset(1'b1);
    idle(64);
    send_break(351);
    chk(n_brk == int'(exp_brk(351)), "R6 break 351 rejected", n_brk, 0);
    chk(spb_now == 6'd32, "R5 hunting count", spb_now, 32);
    send_break(897);
    chk(n_brk == int'(exp_brk(897)), "R6 break 897 rejected", n_brk, 0);

    // R6 R7 R9: good header at 36 clocks per bit, break exactly 352
    header(352, 36);
    chk(n_brk == 1, "R6 break 352 accepted", n_brk, 1);
    chk(n_done == 1 && n_err == 0, "R7 sync done 36", n_done, 1);
    chk(spb_now == 6'(exp_spb(36)), "R7 tuned 36", spb_now, exp_spb(36));
    nb = 0;
    send_frame(8'hC3, 36, 1'b0);
    idle(80);
    check_frame(8'hC3, "R9 identifier at 36");
    chk(spb_now == 6'd32, "R9 count back to nominal", spb_now, 32);

    // R6 R7 R9: break exactly 896, slow side 28
    n_brk = 0; n_done = 0;
    header(896, 28);
    chk(n_brk == 1, "R6 break 896 accepted", n_brk, 1);
    chk(spb_now == 6'(exp_spb(28)), "R7 tuned 28", spb_now, exp_spb(28));
    nb = 0;
    send_frame(8'h81, 28, 1'b0);
    idle(80);
    check_frame(8'h81, "R9 identifier at 28");

    // R8: too fast and too slow sync fields
    n_done = 0; n_err = 0;
    header(416, 20);
    idle(80);
    chk(n_err == 1 && n_done == 0, "R8 sync 20 error", n_err, 1);
    chk(spb_now == 6'(exp_spb(20)), "R8 count after error", spb_now, 32);
    n_err = 0;
    header(416, 45);
    idle(80);
    chk(n_err == 1 && n_done == 0, "R8 sync 45 timeout", n_err, 1);

    // R7 R9: edge of window at 38, random identifier
    begin
      logic [7:0] b;
      b = 8'($urandom);
      n_done = 0;
      header(416, 38);
      chk(n_done == 1 && spb_now == 6'(exp_spb(38)), "R7 tuned 38", spb_now, exp_spb(38));
      nb = 0;
      send_frame(b, 38, 1'b0);
      idle(80);
      check_frame(b, "R9 identifier at 38");
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule